// File: doc/BRIEF.md
# Multi-Write Output Queue

This block is the descriptor queue that sits on one output line of a switch in which every input may deliver a packet to the same output within one time slot. Each clock cycle is one slot. During a slot any subset of the `NUM_IN` input lanes may present a valid packet descriptor. The queue takes all of them in that slot and sends at most one descriptor on the output line.

Arrivals are ordered behind the packets already stored. Within a slot they are ordered by ascending lane index. When the queue holds nothing, the first arrival leaves in the same slot, with no register between input and output. The remaining arrivals fill the store up to its capacity of `DEPTH` entries. Whatever does not fit is discarded, and no backpressure is applied.

Three running counters report accepted, dropped and transmitted packets, so throughput and loss can be measured from outside.

Top module: `multi_write_queue`

## Requirements
- R1: `out_valid` is low in a slot exactly when `occupancy` is 0 and no bit of `in_valid` is set. In every other slot it is high.
- R2: When `occupancy` is 0 and at least one lane is valid, `out_desc` in that same slot equals the descriptor of the lowest-indexed valid lane. Lane i occupies bits `in_desc[i*DESC_W +: DESC_W]`.
- R3: At each clock edge `occupancy` becomes min(max(0, Q + A − 1), DEPTH). Here Q is the occupancy before the edge and A is the number of set bits of `in_valid`.
- R4: Descriptors leave in the order they entered. Packets from an earlier slot leave before packets from a later slot, and packets within one slot leave in ascending lane index.
- R5: The number of packets discarded in a slot is max(0, Q + A − 1 − DEPTH). The discarded ones are the highest-indexed valid lanes of that slot.
- R6: `cnt_sent` rises by one for each slot with `out_valid` high. `cnt_dropped` rises by the discard count of R5. `cnt_accepted` rises by A minus that discard count. All three wrap modulo 2^CNT_W.
- R7: While `rst_n` is low, the queue is empty, all three counters read 0, and `out_valid` is low when no lane is valid.
- R8: `occupancy` never exceeds `DEPTH`.
- R9: When `occupancy` is non-zero, `out_desc` is the oldest stored descriptor, whatever arrives in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | NUM_IN | One valid flag per input lane |
| in_desc | input | NUM_IN*DESC_W | Lane descriptors, lane i at bits i*DESC_W upward |
| out_valid | output | 1 | A descriptor leaves on the output line this slot |
| out_desc | output | DESC_W | Departing descriptor |
| occupancy | output | $clog2(DEPTH+1) | Number of stored descriptors |
| cnt_accepted | output | CNT_W | Packets taken in (cut-through included) |
| cnt_dropped | output | CNT_W | Packets discarded on overflow |
| cnt_sent | output | CNT_W | Packets sent on the output line |

## Verification
The assertions assume that `in_valid` and `in_desc` settle between clock edges and carry no unknown bits. They also assume that a slot's arrivals are fully described by the valid mask, so a lane with its flag low carries nothing the queue must keep. The bench drives every lane from the cycle after an edge with known values, and gives each arriving descriptor a distinct tag so that ordering and drop choice can be observed at the output. It covers every valid mask from every starting occupancy, including the full queue where several lanes overflow at once. A pseudo-random phase then follows.

// File: rtl/mwq_pkg.sv
package mwq_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mwq_rank.sv
module mwq_rank #(
   parameter int NUM_IN = 4,
   parameter int RANK_W = 3
) (
   input  logic [NUM_IN-1:0]             valid,
   output logic [NUM_IN-1:0][RANK_W-1:0] rank,
   output logic [NUM_IN-1:0]             first,
   output logic [RANK_W-1:0]             total
);

   logic [RANK_W-1:0] acc;

   // rank[i] counts valid lanes below i; lowest valid lane is flagged in first
   always_comb begin
      acc = '0;
      for (int i = 0; i < NUM_IN; i++) begin
         rank[i]  = acc;
         first[i] = valid[i] && (acc == '0);
         acc      = acc + RANK_W'(valid[i]);
      end
      total = acc;
   end

endmodule

// File: rtl/mwq_store.sv
module mwq_store #(
   parameter int NUM_IN = 4,
   parameter int DEPTH  = 8,
   parameter int DESC_W = 8,
   parameter int RANK_W = 3,
   parameter int OCC_W  = 4,
   parameter int SUM_W  = 4,
   parameter int PTR_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_IN-1:0]             valid,
   input  logic [NUM_IN*DESC_W-1:0]      desc_flat,
   input  logic [NUM_IN-1:0][RANK_W-1:0] rank,
   input  logic [RANK_W-1:0]             total,
   output logic [OCC_W-1:0]              occ,
   output logic [DESC_W-1:0]             head_desc,
   output logic                          advance,
   output logic [RANK_W-1:0]             drops
);

   localparam bit                IS_POW2 = mwq_pkg::is_pow2(DEPTH);
   localparam logic [SUM_W-1:0]  DEPTH_S = SUM_W'(DEPTH);
   localparam logic [OCC_W-1:0]  DEPTH_O = OCC_W'(DEPTH);

   logic [DESC_W-1:0] mem [DEPTH];
   logic [DESC_W-1:0] desc_a [NUM_IN];
   logic [PTR_W-1:0]  head;
   logic [PTR_W-1:0]  head_inc;
   logic [SUM_W-1:0]  seq [NUM_IN];
   logic [PTR_W-1:0]  slot [NUM_IN];
   logic [NUM_IN-1:0] keep;
   logic [SUM_W-1:0]  grand;
   logic [OCC_W-1:0]  occ_nx;

   for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_lane
      assign desc_a[gi] = desc_flat[gi*DESC_W +: DESC_W];
   end

   // Position in the slot's combined order: stored packets first, then lanes.
   // Position 0 departs; positions 1..DEPTH are kept.
   always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
         seq[i]  = SUM_W'(occ) + SUM_W'(rank[i]);
         keep[i] = valid[i] && (seq[i] != '0) && (seq[i] <= DEPTH_S);
      end
   end

   if (IS_POW2) begin : g_wrap_mask
      always_comb begin
         for (int i = 0; i < NUM_IN; i++) begin
            slot[i] = PTR_W'(SUM_W'(head) + seq[i]);
         end
         head_inc = head + 1'b1;
      end
   end else begin : g_wrap_cmp
      localparam logic [SUM_W:0] DEPTH_W = (SUM_W+1)'(DEPTH);
      logic [SUM_W:0] raw [NUM_IN];
      always_comb begin
         for (int i = 0; i < NUM_IN; i++) begin
            raw[i]  = (SUM_W+1)'(head) + (SUM_W+1)'(seq[i]);
            slot[i] = (raw[i] >= DEPTH_W) ? PTR_W'(raw[i] - DEPTH_W)
                                          : PTR_W'(raw[i]);
         end
         head_inc = (head == PTR_W'(DEPTH - 1)) ? '0 : head + 1'b1;
      end
   end

   always_comb begin
      grand   = SUM_W'(occ) + SUM_W'(total);
      advance = (grand != '0);
      drops   = '0;
      if (!advance) begin
         occ_nx = '0;
      end else if ((grand - 1'b1) > DEPTH_S) begin
         occ_nx = DEPTH_O;
         drops  = RANK_W'(grand - 1'b1 - DEPTH_S);
      end else begin
         occ_nx = OCC_W'(grand - 1'b1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ  <= '0;
         head <= '0;
      end else begin
         occ <= occ_nx;
         if (advance) head <= head_inc;
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < DEPTH; k++) begin
         for (int i = 0; i < NUM_IN; i++) begin
            if (keep[i] && (slot[i] == PTR_W'(k))) mem[k] <= desc_a[i];
         end
      end
   end

   assign head_desc = mem[head];

   p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= DEPTH_O);

   p_occ_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (occ != '0 && total == '0) |=> (occ == $past(occ) - 1'b1));

   p_empty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0 && total <= RANK_W'(1)) |=> (occ == '0));

   p_full_after_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drops != '0) |=> (occ == DEPTH_O));

endmodule

// File: rtl/mwq_counters.sv
module mwq_counters #(
   parameter int CNT_W  = 16,
   parameter int RANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic [RANK_W-1:0] total,
   input  logic [RANK_W-1:0] drops,
   output logic [CNT_W-1:0]  cnt_acc,
   output logic [CNT_W-1:0]  cnt_drop,
   output logic [CNT_W-1:0]  cnt_sent
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_acc  <= '0;
         cnt_drop <= '0;
         cnt_sent <= '0;
      end else begin
         cnt_acc  <= cnt_acc + CNT_W'(total) - CNT_W'(drops);
         cnt_drop <= cnt_drop + CNT_W'(drops);
         if (advance) cnt_sent <= cnt_sent + 1'b1;
      end
   end

   p_sent_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (cnt_sent == $past(cnt_sent) + 1'b1));

   p_quiet_counters_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (total == '0) |=> ($stable(cnt_acc) && $stable(cnt_drop)));

endmodule

// File: rtl/multi_write_queue.sv
module multi_write_queue #(
   parameter int NUM_IN = 4,
   parameter int DEPTH  = 8,
   parameter int DESC_W = 8,
   parameter int CNT_W  = 16,
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_IN-1:0]        in_valid,
   input  logic [NUM_IN*DESC_W-1:0] in_desc,
   output logic                     out_valid,
   output logic [DESC_W-1:0]        out_desc,
   output logic [OCC_W-1:0]         occupancy,
   output logic [CNT_W-1:0]         cnt_accepted,
   output logic [CNT_W-1:0]         cnt_dropped,
   output logic [CNT_W-1:0]         cnt_sent
);

   localparam int RANK_W = $clog2(NUM_IN + 1);
   localparam int SUM_W  = $clog2(DEPTH + NUM_IN + 1);
   localparam int PTR_W  = $clog2(DEPTH);

   if (NUM_IN < 1) begin : g_bad_lanes
      $error("multi_write_queue: NUM_IN must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("multi_write_queue: DEPTH must be at least 2");
   end
   if (DESC_W < 1 || CNT_W < 2) begin : g_bad_width
      $error("multi_write_queue: DESC_W or CNT_W too small");
   end

   logic [NUM_IN-1:0][RANK_W-1:0] rank;
   logic [NUM_IN-1:0]             first;
   logic [RANK_W-1:0]             total;
   logic [RANK_W-1:0]             drops;
   logic                          advance;
   logic [DESC_W-1:0]             head_desc;
   logic [DESC_W-1:0]             cut_desc;

   mwq_rank #(.NUM_IN(NUM_IN), .RANK_W(RANK_W)) u_rank (
      .valid (in_valid),
      .rank  (rank),
      .first (first),
      .total (total)
   );

   mwq_store #(
      .NUM_IN (NUM_IN), .DEPTH (DEPTH), .DESC_W (DESC_W), .RANK_W (RANK_W),
      .OCC_W  (OCC_W),  .SUM_W (SUM_W), .PTR_W  (PTR_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (in_valid),
      .desc_flat (in_desc),
      .rank      (rank),
      .total     (total),
      .occ       (occupancy),
      .head_desc (head_desc),
      .advance   (advance),
      .drops     (drops)
   );

   mwq_counters #(.CNT_W(CNT_W), .RANK_W(RANK_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (advance),
      .total    (total),
      .drops    (drops),
      .cnt_acc  (cnt_accepted),
      .cnt_drop (cnt_dropped),
      .cnt_sent (cnt_sent)
   );

   // Cut-through selection: lowest valid lane
   always_comb begin
      cut_desc = '0;
      for (int i = 0; i < NUM_IN; i++) begin
         if (first[i]) cut_desc = cut_desc | in_desc[i*DESC_W +: DESC_W];
      end
   end

   assign out_valid = advance;
   assign out_desc  = (occupancy != '0) ? head_desc : cut_desc;

   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy == '0 && in_valid == '0) |-> !out_valid);

   p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy != '0) |-> out_valid);

   p_cut_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy == '0 && in_valid[0]) |-> (out_desc == in_desc[DESC_W-1:0]));

endmodule

// File: tb/tb_multi_write_queue.sv
module tb_multi_write_queue;

   localparam int N  = 3;
   localparam int B  = 5;
   localparam int DW = 8;
   localparam int CW = 16;
   localparam int OW = $clog2(B + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  in_valid;
   logic [N*DW-1:0] in_desc;
   logic          out_valid;
   logic [DW-1:0] out_desc;
   logic [OW-1:0] occupancy;
   logic [CW-1:0] cnt_accepted, cnt_dropped, cnt_sent;

   always #5 clk = ~clk;

   multi_write_queue #(.NUM_IN(N), .DEPTH(B), .DESC_W(DW), .CNT_W(CW)) dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_desc (in_desc),
      .out_valid (out_valid), .out_desc (out_desc), .occupancy (occupancy),
      .cnt_accepted (cnt_accepted), .cnt_dropped (cnt_dropped),
      .cnt_sent (cnt_sent)
   );

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 0;
   int model [0:15];
   int m_cnt = 0;
   int e_acc = 0, e_drop = 0, e_sent = 0;
   int tag   = 1;

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called 1 time unit after a rising edge; returns 1 unit after the next.
   task automatic slot(input logic [N-1:0] mask);
      int d [N];
      int lst [0:15];
      int len, kept, drp, arr, fi;
      string lbl;
      for (int i = 0; i < N; i++) begin
         d[i] = tag & 8'hFF;
         tag++;
         in_desc[i*DW +: DW] = DW'(d[i]);
      end
      in_valid = mask;
      #3;
      check("R3 occupancy", int'(occupancy), m_cnt);
      check("R8 bound", int'(occupancy <= OW'(B)), 1);
      check("R6 accepted", int'(cnt_accepted), e_acc & 16'hFFFF);
      check("R5 dropped", int'(cnt_dropped), e_drop & 16'hFFFF);
      check("R6 sent", int'(cnt_sent), e_sent & 16'hFFFF);
      check("R1 out_valid", int'(out_valid), int'((m_cnt > 0) || (mask != '0)));
      fi = -1;
      for (int i = N - 1; i >= 0; i--) if (mask[i]) fi = i;
      if (m_cnt > 0) begin
         lbl = (mask == '0) ? "R4 order" : "R9 head priority";
         check(lbl, int'(out_desc), model[0]);
      end else if (fi >= 0) begin
         check("R2 cut-through", int'(out_desc), d[fi]);
      end
      len = 0;
      for (int k = 0; k < m_cnt; k++) begin lst[len] = model[k]; len++; end
      arr = 0;
      for (int i = 0; i < N; i++) if (mask[i]) begin lst[len] = d[i]; len++; arr++; end
      if (len > 0) begin
         e_sent++;
         kept = (len - 1 > B) ? B : len - 1;
         drp  = len - 1 - kept;
         for (int k = 0; k < kept; k++) model[k] = lst[k + 1];
         m_cnt  = kept;
         e_drop += drp;
         e_acc  += arr - drp;
      end
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_errs++;
         n_checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr;
      rst_n    = 1'b0;
      in_valid = '0;
      in_desc  = '0;
      #1;
      check("R7 reset occupancy", int'(occupancy), 0);
      check("R7 reset accepted", int'(cnt_accepted), 0);
      check("R7 reset dropped", int'(cnt_dropped), 0);
      check("R7 reset sent", int'(cnt_sent), 0);
      check("R7 reset out_valid", int'(out_valid), 0);
      @(posedge clk);
      @(posedge clk);
      #1;
      rst_n = 1'b1;

      // Every mask from every starting occupancy
      for (int fill = 0; fill <= B; fill++) begin
         for (int m = 0; m < (1 << N); m++) begin
            while (m_cnt > 0) slot('0);
            while (m_cnt < fill) slot((fill - m_cnt >= 2) ? 3'b111 : 3'b011);
            slot(N'(m));
            slot('0);
         end
      end

      // Sustained overload, then drain
      for (int k = 0; k < 12; k++) slot(3'b111);
      for (int k = 0; k < 8; k++) slot('0);

      // Pseudo-random masks
      lfsr = 8'hA5;
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         slot(lfsr[N-1:0]);
      end
      for (int k = 0; k < 8; k++) slot('0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule